// File: doc/BRIEF.md
# Windowed Integer Register File

This block is the integer register file of a processor that gives each procedure its own window of registers. Storage holds eight global registers and a ring of 32 windows. Neighbouring windows overlap, so a caller can pass arguments to a callee in registers without copying them. A 5-bit current window pointer picks the active window. Every logical register number on the two read ports and the one write port is turned into a physical index into a flat array of 520 words.

A save command moves the pointer down one window, which is the move made on a procedure call. A restore command moves it up one window, on return. Both moves wrap around the ring. A 32-bit invalid mask has one bit per window, and it is checked against the window that a move would enter. If that bit is set, the pointer does not move and an overflow flag (on save) or an underflow flag (on restore) is raised for one cycle. Spilling or filling the window to memory is left to the trap handler around the block.

Top module: `winreg_file`

## Requirements
- R1: A synchronous active-high reset sets the window pointer to 0, clears both flags and clears the invalid mask. So the first save after reset moves the pointer to 31 even if all mask bits were set before the reset.
- R2: Logical registers 0 to 7 are globals. The same global is reached from every window.
- R3: Logical register 0 always reads as zero. A write to it has no effect.
- R4: Logical registers 8 to 15 are the outputs of the current window w. Output k of window w is the same storage as logical input 24+k of window (w-1) mod 32.
- R5: Logical registers 16 to 23 are locals, which are private to each window. A local written in one window does not change the local with the same number in a neighbouring window.
- R6: A save with an unmasked target sets the pointer to (pointer-1) mod 32 at the next clock edge, so 0 wraps to 31.
- R7: A restore with an unmasked target sets the pointer to (pointer+1) mod 32 at the next clock edge, so 31 wraps to 0.
- R8: A save whose target window has its mask bit set leaves the pointer unchanged. The overflow flag is then high for exactly the following cycle.
- R9: A restore whose target window has its mask bit set leaves the pointer unchanged. The underflow flag is then high for exactly the following cycle.
- R10: Reads are combinational. A read of a register that is being written in the same cycle returns the old value. The new value is read from the cycle after the write edge.
- R11: A save and a restore asserted together are ignored. The pointer is unchanged and neither flag is raised.
- R12: A write issued in the same cycle as a save is translated through the window that was current before the move.
- R13: A mask load takes effect at the clock edge. A save or restore in the same cycle as the load is checked against the old mask. Mask bit i belongs to window i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_num | input | 5 | Logical register number for read port A |
| rd_a_data | output | DATA_W | Read data for port A (combinational) |
| rd_b_num | input | 5 | Logical register number for read port B |
| rd_b_data | output | DATA_W | Read data for port B (combinational) |
| wr_en | input | 1 | Write enable |
| wr_num | input | 5 | Logical register number to write |
| wr_data | input | DATA_W | Write data |
| save_req | input | 1 | Move the window pointer down one window |
| restore_req | input | 1 | Move the window pointer up one window |
| mask_we | input | 1 | Load the invalid mask |
| mask_wdata | input | 32 | New invalid mask, bit i for window i |
| cwp | output | 5 | Current window pointer |
| win_overflow | output | 1 | One-cycle flag: a save was blocked by the mask |
| win_underflow | output | 1 | One-cycle flag: a restore was blocked by the mask |

## Verification
The properties assume that the command inputs are stable around each rising edge. Inputs are changed only at the falling edge, so the pointer, the mask and the flags each follow one clean command per cycle. They also assume that reset is held for at least one edge before any command is counted. The stimulus never reads a physical register before writing it. That keeps every data check free of unknown values, since the array itself is not reset. Blocked moves are set up by loading the mask in a cycle of its own, except in the one case that tests a load and a move in the same cycle.

// File: rtl/wrf_pkg.sv
package wrf_pkg;

    // Window geometry
    localparam int WIN_W    = 5;
    localparam int NWIN     = 1 << WIN_W;
    localparam int GRP_W    = 3;
    localparam int GRP_SZ   = 1 << GRP_W;
    localparam int LREG_W   = GRP_W + 2;
    localparam int WIN_SPAN = 2 * GRP_SZ;                 // locals + inputs owned by a window
    localparam int NPHYS    = GRP_SZ + NWIN * WIN_SPAN;   // 8 + 32*16 = 520
    localparam int PHYS_W   = $clog2(NPHYS);
    localparam int NRD      = 2;
    localparam int NPORT    = NRD + 1;

    typedef logic [WIN_W-1:0]  win_t;
    typedef logic [LREG_W-1:0] lreg_t;
    typedef logic [PHYS_W-1:0] phys_t;
    typedef logic [NWIN-1:0]   wmask_t;

    // The two upper bits of a logical number select the group
    typedef enum logic [1:0] {
        GRP_GLOBAL = 2'd0,
        GRP_OUT    = 2'd1,
        GRP_LOCAL  = 2'd2,
        GRP_IN     = 2'd3
    } grp_e;

    typedef enum logic [1:0] {
        MV_NONE    = 2'd0,
        MV_SAVE    = 2'd1,
        MV_RESTORE = 2'd2
    } move_e;

    typedef struct packed {
        move_e kind;
        win_t  target;
        logic  blocked;
    } move_t;

    // Window that a move would enter
    function automatic win_t win_step(win_t w, move_e k);
        win_t r;
        case (k)
            MV_SAVE:    r = w - win_t'(1);
            MV_RESTORE: r = w + win_t'(1);
            default:    r = w;
        endcase
        return r;
    endfunction

    // Logical register number to physical array index.
    // Layout: globals first, then per window: locals, then inputs.
    // The outputs of window w alias the inputs of window w-1.
    function automatic phys_t map_reg(win_t w, lreg_t r);
        grp_e g;
        int   k;
        int   idx;
        win_t owner;
        g   = grp_e'(r[LREG_W-1:GRP_W]);
        k   = int'(r[GRP_W-1:0]);
        idx = k;
        case (g)
            GRP_GLOBAL: idx = k;
            GRP_OUT: begin
                owner = w - win_t'(1);
                idx   = GRP_SZ + int'(owner) * WIN_SPAN + GRP_SZ + k;
            end
            GRP_LOCAL: idx = GRP_SZ + int'(w) * WIN_SPAN + k;
            GRP_IN:    idx = GRP_SZ + int'(w) * WIN_SPAN + GRP_SZ + k;
            default:   idx = k;
        endcase
        return phys_t'(idx);
    endfunction

endpackage

// File: rtl/wrf_xlate.sv
module wrf_xlate
    import wrf_pkg::*;
(
    input  win_t  win,
    input  lreg_t lnum,
    output phys_t pidx
);

    always_comb begin
        pidx = map_reg(win, lnum);
    end

endmodule

// File: rtl/wrf_wptr.sv
module wrf_wptr
    import wrf_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   save_req,
    input  logic   restore_req,
    input  logic   mask_we,
    input  wmask_t mask_wdata,
    output win_t   cwp,
    output wmask_t mask,
    output logic   ovf,
    output logic   unf
);

    move_t mv;

    always_comb begin
        mv.kind = MV_NONE;
        if (save_req && !restore_req)
            mv.kind = MV_SAVE;
        else if (restore_req && !save_req)
            mv.kind = MV_RESTORE;
        mv.target  = win_step(cwp, mv.kind);
        mv.blocked = (mv.kind != MV_NONE) && mask[mv.target];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cwp  <= '0;
            mask <= '0;
            ovf  <= 1'b0;
            unf  <= 1'b0;
        end else begin
            if (mv.kind != MV_NONE && !mv.blocked)
                cwp <= mv.target;
            ovf <= mv.blocked && (mv.kind == MV_SAVE);
            unf <= mv.blocked && (mv.kind == MV_RESTORE);
            if (mask_we)
                mask <= mask_wdata;
        end
    end

endmodule

// File: rtl/wrf_store.sv
module wrf_store
    import wrf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              we,
    input  phys_t             widx,
    input  logic [DATA_W-1:0] wdata,
    input  phys_t             ridx  [NRD],
    output logic [DATA_W-1:0] rdata [NRD]
);

    logic [DATA_W-1:0] mem [NPHYS];

    // Physical slot 0 is global 0: never written, always read as zero
    always_ff @(posedge clk) begin
        if (we && widx != '0)
            mem[widx] <= wdata;
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        always_comb begin
            if (ridx[p] == '0)
                rdata[p] = '0;
            else
                rdata[p] = mem[ridx[p]];
        end
    end

endmodule

// File: rtl/winreg_file.sv
module winreg_file
    import wrf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [LREG_W-1:0]      rd_a_num,
    output logic [DATA_W-1:0]      rd_a_data,
    input  logic [LREG_W-1:0]      rd_b_num,
    output logic [DATA_W-1:0]      rd_b_data,
    input  logic                   wr_en,
    input  logic [LREG_W-1:0]      wr_num,
    input  logic [DATA_W-1:0]      wr_data,
    input  logic                   save_req,
    input  logic                   restore_req,
    input  logic                   mask_we,
    input  logic [NWIN-1:0]        mask_wdata,
    output logic [WIN_W-1:0]       cwp,
    output logic                   win_overflow,
    output logic                   win_underflow
);

    localparam int WR_PORT = NRD;

    win_t              cwp_q;
    wmask_t            mask_q;
    lreg_t             port_num [NPORT];
    phys_t             port_idx [NPORT];
    phys_t             rd_idx   [NRD];
    logic [DATA_W-1:0] rd_data  [NRD];

    wrf_wptr u_wptr (
        .clk         (clk),
        .rst         (rst),
        .save_req    (save_req),
        .restore_req (restore_req),
        .mask_we     (mask_we),
        .mask_wdata  (mask_wdata),
        .cwp         (cwp_q),
        .mask        (mask_q),
        .ovf         (win_overflow),
        .unf         (win_underflow)
    );

    assign port_num[0]       = rd_a_num;
    assign port_num[1]       = rd_b_num;
    assign port_num[WR_PORT] = wr_num;

    // One translator per port, all through the pre-move pointer
    for (genvar p = 0; p < NPORT; p++) begin : g_xl
        wrf_xlate u_xl (
            .win  (cwp_q),
            .lnum (port_num[p]),
            .pidx (port_idx[p])
        );
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rdi
        assign rd_idx[p] = port_idx[p];
    end

    wrf_store #(.DATA_W(DATA_W)) u_store (
        .clk   (clk),
        .we    (wr_en),
        .widx  (port_idx[WR_PORT]),
        .wdata (wr_data),
        .ridx  (rd_idx),
        .rdata (rd_data)
    );

    assign rd_a_data = rd_data[0];
    assign rd_b_data = rd_data[1];
    assign cwp       = cwp_q;

endmodule

// File: rtl/winreg_file_chk.sv
module winreg_file_chk
    import wrf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              save_req,
    input logic              restore_req,
    input logic              mask_we,
    input wmask_t            mask_wdata,
    input wmask_t            wim,
    input win_t              cwp,
    input logic              ovf,
    input logic              unf,
    input lreg_t             rd_a_num,
    input logic [DATA_W-1:0] rd_a_data
);

    logic do_save, do_rest;
    assign do_save = save_req && !restore_req;
    assign do_rest = restore_req && !save_req;

    a_r6_save_moves: assert property (@(posedge clk) disable iff (rst)
        (do_save && !wim[win_t'(cwp - win_t'(1))]) |=> (cwp == win_t'($past(cwp) - win_t'(1))));

    a_r7_restore_moves: assert property (@(posedge clk) disable iff (rst)
        (do_rest && !wim[win_t'(cwp + win_t'(1))]) |=> (cwp == win_t'($past(cwp) + win_t'(1))));

    a_r8_overflow_hold: assert property (@(posedge clk) disable iff (rst)
        (do_save && wim[win_t'(cwp - win_t'(1))]) |=> (ovf && !unf && $stable(cwp)));

    a_r9_underflow_hold: assert property (@(posedge clk) disable iff (rst)
        (do_rest && wim[win_t'(cwp + win_t'(1))]) |=> (unf && !ovf && $stable(cwp)));

    a_r11_both_ignored: assert property (@(posedge clk) disable iff (rst)
        (save_req && restore_req) |=> ($stable(cwp) && !ovf && !unf));

    a_r8_flag_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf) |-> $past(do_save));

    a_r13_mask_load: assert property (@(posedge clk) disable iff (rst)
        mask_we |=> (wim == $past(mask_wdata)));

    a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ovf, unf}));

    always_ff @(negedge clk) begin
        if (!rst) begin
            a_r3_zero_read: assert (rd_a_num != '0 || rd_a_data == '0);
        end
    end

endmodule

bind winreg_file winreg_file_chk #(.DATA_W(DATA_W)) i_chk (
    .clk         (clk),
    .rst         (rst),
    .save_req    (save_req),
    .restore_req (restore_req),
    .mask_we     (mask_we),
    .mask_wdata  (mask_wdata),
    .wim         (mask_q),
    .cwp         (cwp_q),
    .ovf         (win_overflow),
    .unf         (win_underflow),
    .rd_a_num    (rd_a_num),
    .rd_a_data   (rd_a_data)
);

// File: tb/test_winreg_file.sv
module test_winreg_file;

    localparam int CLK_PERIOD = 10;
    localparam int DW         = 32;
    localparam int NVEC       = 13;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [4:0]    rd_a_num = '0, rd_b_num = '0, wr_num = '0;
    logic [DW-1:0] rd_a_data, rd_b_data, wr_data = '0;
    logic          wr_en = 1'b0, save_req = 1'b0, restore_req = 1'b0, mask_we = 1'b0;
    logic [31:0]   mask_wdata = '0;
    logic [4:0]    cwp;
    logic          win_overflow, win_underflow;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    winreg_file #(.DATA_W(DW)) i_winreg_file (
        .clk(clk), .rst(rst),
        .rd_a_num(rd_a_num), .rd_a_data(rd_a_data),
        .rd_b_num(rd_b_num), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_num(wr_num), .wr_data(wr_data),
        .save_req(save_req), .restore_req(restore_req),
        .mask_we(mask_we), .mask_wdata(mask_wdata),
        .cwp(cwp), .win_overflow(win_overflow), .win_underflow(win_underflow)
    );

    typedef struct packed {
        logic        sv;
        logic        rs;
        logic        mwe;
        logic [31:0] mval;
        logic [4:0]  ecwp;
        logic        eovf;
        logic        eunf;
        logic [3:0]  req;
    } vec_t;

    // Pointer sequence from reset: commands and the state expected after the edge
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 1'b0, 1'b0, 32'h0,          5'd31, 1'b0, 1'b0, 4'd6 },  // R6 wrap 0 -> 31
        '{1'b0, 1'b1, 1'b0, 32'h0,          5'd0,  1'b0, 1'b0, 4'd7 },  // R7 wrap 31 -> 0
        '{1'b0, 1'b1, 1'b0, 32'h0,          5'd1,  1'b0, 1'b0, 4'd7 },  // R7
        '{1'b0, 1'b0, 1'b1, 32'h0000_0004,  5'd1,  1'b0, 1'b0, 4'd13},  // R13 mark window 2
        '{1'b0, 1'b1, 1'b0, 32'h0,          5'd1,  1'b0, 1'b1, 4'd9 },  // R9 blocked restore
        '{1'b0, 1'b0, 1'b0, 32'h0,          5'd1,  1'b0, 1'b0, 4'd9 },  // R9 flag lasts one cycle
        '{1'b1, 1'b0, 1'b0, 32'h0,          5'd0,  1'b0, 1'b0, 4'd6 },  // R6
        '{1'b0, 1'b0, 1'b1, 32'h8000_0000,  5'd0,  1'b0, 1'b0, 4'd13},  // R13 mark window 31
        '{1'b1, 1'b0, 1'b0, 32'h0,          5'd0,  1'b1, 1'b0, 4'd8 },  // R8 blocked save
        '{1'b1, 1'b1, 1'b0, 32'h0,          5'd0,  1'b0, 1'b0, 4'd11},  // R11 both ignored
        '{1'b1, 1'b0, 1'b1, 32'h0,          5'd0,  1'b1, 1'b0, 4'd13},  // R13 old mask applies
        '{1'b1, 1'b0, 1'b0, 32'h0,          5'd31, 1'b0, 1'b0, 4'd13},  // R13 new mask applies
        '{1'b0, 1'b1, 1'b0, 32'h0,          5'd0,  1'b0, 1'b0, 4'd7 }   // R7
    };

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic clear_inputs();
        wr_en = 1'b0; save_req = 1'b0; restore_req = 1'b0; mask_we = 1'b0;
    endtask

    task automatic write_reg(logic [4:0] n, logic [31:0] d);
        wr_en = 1'b1; wr_num = n; wr_data = d;
        tick();
        clear_inputs();
    endtask

    task automatic move(bit sv, bit rs);
        save_req = sv; restore_req = rs;
        tick();
        clear_inputs();
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tick(); tick();
        rst = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        tick();
        do_reset();
        // R1 reset state
        check("R1 cwp", 32'(cwp), 32'd0);
        check("R1 ovf", 32'(win_overflow), 32'd0);
        check("R1 unf", 32'(win_underflow), 32'd0);

        // Table walk
        for (int i = 0; i < NVEC; i++) begin
            save_req    = VECS[i].sv;
            restore_req = VECS[i].rs;
            mask_we     = VECS[i].mwe;
            mask_wdata  = VECS[i].mval;
            tick();
            clear_inputs();
            check($sformatf("R%0d vec%0d cwp", VECS[i].req, i), 32'(cwp), 32'(VECS[i].ecwp));
            check($sformatf("R%0d vec%0d ovf", VECS[i].req, i), 32'(win_overflow), 32'(VECS[i].eovf));
            check($sformatf("R%0d vec%0d unf", VECS[i].req, i), 32'(win_underflow), 32'(VECS[i].eunf));
        end

        // R1: reset clears a fully set mask
        mask_we = 1'b1; mask_wdata = 32'hFFFF_FFFF;
        tick();
        clear_inputs();
        do_reset();
        move(1'b1, 1'b0);
        check("R1 mask cleared", 32'(cwp), 32'd31);
        move(1'b0, 1'b1);
        check("R1 back to 0", 32'(cwp), 32'd0);

        // R3: register 0 ignores writes
        write_reg(5'd0, 32'hDEAD_BEEF);
        rd_a_num = 5'd0; rd_b_num = 5'd0;
        #1;
        check("R3 port A", rd_a_data, 32'h0);
        check("R3 port B", rd_b_data, 32'h0);

        // R2: global seen from another window
        write_reg(5'd3, 32'h0000_0333);
        move(1'b1, 1'b0);
        rd_b_num = 5'd3;
        #1;
        check("R2 global", rd_b_data, 32'h0000_0333);
        move(1'b0, 1'b1);

        // R10: read during write returns old value
        write_reg(5'd18, 32'h0000_1111);
        wr_en = 1'b1; wr_num = 5'd18; wr_data = 32'h0000_2222; rd_a_num = 5'd18;
        #1;
        check("R10 old value", rd_a_data, 32'h0000_1111);
        tick();
        clear_inputs();
        #1;
        check("R10 new value", rd_a_data, 32'h0000_2222);

        // R4: output of window 0 is input of window 31
        write_reg(5'd10, 32'h0000_A0A0);
        move(1'b1, 1'b0);
        rd_a_num = 5'd26;
        #1;
        check("R4 callee input", rd_a_data, 32'h0000_A0A0);
        move(1'b0, 1'b1);
        rd_a_num = 5'd10;
        #1;
        check("R4 caller output", rd_a_data, 32'h0000_A0A0);

        // R5: locals private per window
        write_reg(5'd17, 32'h0000_5151);
        move(1'b1, 1'b0);
        write_reg(5'd17, 32'h0000_7777);
        rd_b_num = 5'd17;
        #1;
        check("R5 local in 31", rd_b_data, 32'h0000_7777);
        move(1'b0, 1'b1);
        #1;
        check("R5 local in 0", rd_b_data, 32'h0000_5151);

        // R12: write with save uses the pre-move window
        wr_en = 1'b1; wr_num = 5'd9; wr_data = 32'h0000_C3C3; save_req = 1'b1;
        tick();
        clear_inputs();
        rd_a_num = 5'd25;
        #1;
        check("R12 cwp", 32'(cwp), 32'd31);
        check("R12 data", rd_a_data, 32'h0000_C3C3);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule